// File: doc/BRIEF.md
# Mailbox SRAM Zeroization Sequencer

This block wipes the data store of a shared mailbox after each ownership period. While a requester owns the mailbox, every write of the transfer length (in bytes) is folded into a running maximum. When the requester gives the mailbox back, the sequencer walks the SRAM from word 0 upward and writes zeros, one word per granted cycle, until it has covered the largest length seen during that ownership. Words above that span are left untouched.

During the walk the mailbox is in a clearing state. The lock still reads as held, but the requester has already lost all access, so no agent can reach stale data. Only after the last zero word is accepted does the lock read as free. A one-cycle completion pulse marks that moment. Out of reset the mailbox starts owned by the local microcontroller, which is expected to program the full SRAM size as the length and release, so the whole array is wiped after a warm reset. A build with an SRAM depth of zero has no array, and every release completes at once.

Top module: `mbox_zeroize_seq`

## Requirements
- R1: In reset and in the first cycle after it, the lock reads held, requester access is granted, busy and done are low and no SRAM write is requested.
- R2: The span cleared on release comes from the largest length written while the lock was held, including a write in the release cycle, and not from the last length written.
- R3: From the cycle after a release, busy is high, the lock still reads held and requester access is low until the walk ends.
- R4: The walk requests writes of all-zero data to word addresses 0, 1, 2 ... in ascending order, covering ceil(maxlen / (DATA_W/8)) words, where maxlen is in bytes.
- R5: A write request that is not granted keeps the same address and is repeated next cycle, and the address advances only on a granted write.
- R6: The lock reads free in the cycle after the last granted write; done is high for exactly that one cycle and busy falls in the same cycle.
- R7: With a maximum length of 0, the walk takes one busy cycle and makes no writes.
- R8: A maximum length larger than the SRAM is clamped, so the walk covers all SRAM_DEPTH words.
- R9: The tracked maximum returns to 0 when the lock becomes free, so a following ownership with no length write clears nothing.
- R10: A release outside the held state, a length write outside the held state and an acquire outside the free state have no effect on the lock, access, busy or the number of words cleared.
- R11: With SRAM_DEPTH = 0, every release completes after one busy cycle with no write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acquire_i | input | 1 | Lock acquired by an agent (accepted only when free) |
| release_i | input | 1 | Owner cleared its execute flag (accepted only when held) |
| dlen_we_i | input | 1 | Length register written |
| dlen_i | input | DLEN_W | Written length in bytes |
| sram_gnt_i | input | 1 | Arbiter grant for the SRAM write port |
| sram_we_o | output | 1 | SRAM write request |
| sram_addr_o | output | max(1, clog2(SRAM_DEPTH)) | SRAM word address |
| sram_wdata_o | output | DATA_W | SRAM write data (zero) |
| lock_held_o | output | 1 | Lock reads as held (held or clearing) |
| req_access_o | output | 1 | Owner may access the mailbox |
| busy_o | output | 1 | Zeroization walk in progress |
| done_o | output | 1 | One-cycle pulse when the lock becomes free |

## Verification
The bench builds two copies with shared stimulus: one with a 16-word, 32-bit SRAM and a 12-bit length, and one with a depth of zero. The small depth lets a length of 1000 bytes reach the clamp and a full wipe finish in a few cycles, while byte lengths such as 13 and 20 bring the round-up to whole words within reach. The zero-depth copy runs the same releases and shows the immediate finish. Grant patterns that are always on, that alternate, and that are mostly off exercise the stall rule.

// File: rtl/zs_pkg.sv
package zs_pkg;
   typedef enum logic [1:0] {
      ZS_FREE  = 2'd0,
      ZS_HELD  = 2'd1,
      ZS_CLEAR = 2'd2
   } zs_state_e;
endpackage

// File: rtl/zs_maxlen_trk.sv
module zs_maxlen_trk #(
   parameter int DLEN_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en,
   input  logic [DLEN_W-1:0] upd_val,
   input  logic              clr,
   output logic [DLEN_W-1:0] max_nxt
);
   logic [DLEN_W-1:0] max_q;

   assign max_nxt = (upd_en && (upd_val > max_q)) ? upd_val : max_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   max_q <= '0;
      else if (clr) max_q <= '0;
      else          max_q <= max_nxt;
   end

   // R2: the running maximum never shrinks while no clear is requested
   p_no_shrink_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (max_q >= $past(max_q)));
   // R9: a clear empties the maximum
   p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (max_q == '0));
endmodule

// File: rtl/zs_span_calc.sv
module zs_span_calc #(
   parameter int DLEN_W = 12,
   parameter int BPW    = 4,
   parameter int DEPTH  = 16,
   parameter int CW     = 5
) (
   input  logic [DLEN_W-1:0] len,
   output logic [CW-1:0]     nwords
);
   generate
      if (DEPTH == 0) begin : g_absent
         logic unused_len;
         assign unused_len = ^len;
         assign nwords     = '0;
      end else begin : g_present
         localparam int SH = $clog2(BPW);
         localparam logic [DLEN_W:0] DEPTH_L = (DLEN_W+1)'(DEPTH);
         logic [DLEN_W:0] up;
         assign up     = ({1'b0, len} + (DLEN_W+1)'(BPW-1)) >> SH;
         assign nwords = (up >= DEPTH_L) ? CW'(DEPTH) : up[CW-1:0];
      end
   endgenerate
endmodule

// File: rtl/zs_walker.sv
module zs_walker #(
   parameter int AW     = 4,
   parameter int CW     = 5,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              active,
   input  logic [CW-1:0]     span,
   input  logic              gnt,
   output logic              we_o,
   output logic [AW-1:0]     addr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              finish
);
   logic [CW-1:0] pos_q, span_q, pos_nxt;
   logic          adv;

   assign we_o    = active && (pos_q != span_q);
   assign adv     = we_o && gnt;
   assign pos_nxt = pos_q + CW'(adv);
   assign finish  = active && (pos_nxt == span_q);
   assign addr_o  = pos_q[AW-1:0];
   assign wdata_o = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= '0;
         span_q <= '0;
      end else if (start) begin
         pos_q  <= '0;
         span_q <= span;
      end else begin
         pos_q  <= pos_nxt;
      end
   end

   // R5: an ungranted request repeats at the same address
   p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (we_o && !gnt) |=> (we_o && addr_o == $past(addr_o)));
   // R4: a granted request that is not the last moves to the next word
   p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (we_o && gnt && !finish) |=> (we_o && addr_o == $past(addr_o) + AW'(1)));
   // R4: write data is always zero
   p_zero_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      we_o |-> (wdata_o == '0));
endmodule

// File: rtl/mbox_zeroize_seq.sv
module mbox_zeroize_seq
   import zs_pkg::*;
#(
   parameter int SRAM_DEPTH = 16,
   parameter int DATA_W     = 32,
   parameter int DLEN_W     = 12,
   localparam int AW        = (SRAM_DEPTH <= 1) ? 1 : $clog2(SRAM_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acquire_i,
   input  logic              release_i,
   input  logic              dlen_we_i,
   input  logic [DLEN_W-1:0] dlen_i,
   input  logic              sram_gnt_i,
   output logic              sram_we_o,
   output logic [AW-1:0]     sram_addr_o,
   output logic [DATA_W-1:0] sram_wdata_o,
   output logic              lock_held_o,
   output logic              req_access_o,
   output logic              busy_o,
   output logic              done_o
);
   localparam int BPW = DATA_W / 8;
   localparam int CW  = (SRAM_DEPTH < 1) ? 1 : $clog2(SRAM_DEPTH + 1);

   generate
      if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be a whole number of bytes");
      end
      if ((BPW & (BPW - 1)) != 0) begin : g_bad_bpw
         $error("bytes per word must be a power of two");
      end
      if (DLEN_W < CW || DLEN_W > 30) begin : g_bad_dlen
         $error("DLEN_W must cover the word count and stay below 31 bits");
      end
      if (SRAM_DEPTH < 0) begin : g_bad_depth
         $error("SRAM_DEPTH must not be negative");
      end
   endgenerate

   zs_state_e         state_q, state_d;
   logic              is_free, is_held, is_clear;
   logic              rel_ok, finish, done_q;
   logic [DLEN_W-1:0] max_nxt;
   logic [CW-1:0]     span;

   assign is_free  = (state_q == ZS_FREE);
   assign is_held  = (state_q == ZS_HELD);
   assign is_clear = (state_q == ZS_CLEAR);
   assign rel_ok   = is_held && release_i;

   zs_maxlen_trk #(.DLEN_W(DLEN_W)) u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd_en  (is_held && dlen_we_i),
      .upd_val (dlen_i),
      .clr     (finish),
      .max_nxt (max_nxt)
   );

   zs_span_calc #(.DLEN_W(DLEN_W), .BPW(BPW), .DEPTH(SRAM_DEPTH), .CW(CW)) u_span (
      .len    (max_nxt),
      .nwords (span)
   );

   zs_walker #(.AW(AW), .CW(CW), .DATA_W(DATA_W)) u_walk (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (rel_ok),
      .active  (is_clear),
      .span    (span),
      .gnt     (sram_gnt_i),
      .we_o    (sram_we_o),
      .addr_o  (sram_addr_o),
      .wdata_o (sram_wdata_o),
      .finish  (finish)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ZS_FREE:  if (acquire_i) state_d = ZS_HELD;
         ZS_HELD:  if (release_i) state_d = ZS_CLEAR;
         ZS_CLEAR: if (finish)    state_d = ZS_FREE;
         default:                 state_d = ZS_HELD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ZS_HELD;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= is_clear && finish;
      end
   end

   assign lock_held_o  = !is_free;
   assign req_access_o = is_held;
   assign busy_o       = is_clear;
   assign done_o       = done_q;

   // R3: while clearing the lock stays held and the owner is shut out
   p_shut_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (lock_held_o && !req_access_o));
   // R6: done only follows a walk and lands on a free lock
   p_done_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!lock_held_o && !busy_o && $past(busy_o)));
   // R6: done lasts one cycle
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R10: writes only happen during the walk
   p_we_in_walk_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sram_we_o |-> busy_o);
   // R3: a release while held enters the walk
   p_rel_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_access_o && release_i) |=> busy_o);
endmodule

// File: tb/sim_mbox_zeroize_seq.sv
`timescale 1ns/100ps
module sim_zs_model #(
   parameter int DEPTH = 16,
   parameter int BPW   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic acq,
   input  logic rel,
   input  logic dwe,
   input  int   dlen,
   input  logic gnt,
   output logic m_lock,
   output logic m_acc,
   output logic m_busy,
   output logic m_we,
   output int   m_addr,
   output logic m_done
);
   int st, maxl, pos, nw;
   logic dn;

   always @(posedge clk) begin
      if (!rst_n) begin
         st = 1; maxl = 0; pos = 0; nw = 0; dn = 1'b0;
      end else begin
         dn = 1'b0;
         case (st)
            0: if (acq) st = 1;
            1: begin
               if (dwe && dlen > maxl) maxl = dlen;
               if (rel) begin
                  nw = (maxl + BPW - 1) / BPW;
                  if (nw > DEPTH) nw = DEPTH;
                  pos = 0;
                  st = 2;
               end
            end
            default: begin
               if (pos < nw && gnt) pos = pos + 1;
               if (pos == nw) begin st = 0; dn = 1'b1; maxl = 0; end
            end
         endcase
      end
   end

   assign m_lock = (st != 0);
   assign m_acc  = (st == 1);
   assign m_busy = (st == 2);
   assign m_we   = (st == 2) && (pos < nw);
   assign m_addr = pos;
   assign m_done = dn;
endmodule

module sim_mbox_zeroize_seq;
   localparam int DLW = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acq = 1'b0, rel = 1'b0, dwe = 1'b0, gnt = 1'b1;
   logic [DLW-1:0] dlen = '0;
   int gnt_mode = 0;
   int errs = 0, checks = 0, cyc = 0;
   int wr0 = 0;
   bit comparing = 1'b0;

   always #2.5 clk = ~clk;

   logic        we0, lk0, ac0, bz0, dn0;
   logic [3:0]  ad0;
   logic [31:0] wd0;
   logic        we1, lk1, ac1, bz1, dn1;
   logic [0:0]  ad1;
   logic [31:0] wd1;

   mbox_zeroize_seq #(.SRAM_DEPTH(16), .DATA_W(32), .DLEN_W(DLW)) u0 (
      .clk(clk), .rst_n(rst_n), .acquire_i(acq), .release_i(rel),
      .dlen_we_i(dwe), .dlen_i(dlen), .sram_gnt_i(gnt),
      .sram_we_o(we0), .sram_addr_o(ad0), .sram_wdata_o(wd0),
      .lock_held_o(lk0), .req_access_o(ac0), .busy_o(bz0), .done_o(dn0));

   mbox_zeroize_seq #(.SRAM_DEPTH(0), .DATA_W(32), .DLEN_W(DLW)) u1 (
      .clk(clk), .rst_n(rst_n), .acquire_i(acq), .release_i(rel),
      .dlen_we_i(dwe), .dlen_i(dlen), .sram_gnt_i(gnt),
      .sram_we_o(we1), .sram_addr_o(ad1), .sram_wdata_o(wd1),
      .lock_held_o(lk1), .req_access_o(ac1), .busy_o(bz1), .done_o(dn1));

   logic ml0, ma0, mb0, mw0, md0, ml1, ma1, mb1, mw1, md1;
   int   mad0, mad1;

   sim_zs_model #(.DEPTH(16), .BPW(4)) m0 (
      .clk(clk), .rst_n(rst_n), .acq(acq), .rel(rel), .dwe(dwe), .dlen(int'(dlen)),
      .gnt(gnt), .m_lock(ml0), .m_acc(ma0), .m_busy(mb0), .m_we(mw0),
      .m_addr(mad0), .m_done(md0));
   sim_zs_model #(.DEPTH(0), .BPW(4)) m1 (
      .clk(clk), .rst_n(rst_n), .acq(acq), .rel(rel), .dwe(dwe), .dlen(int'(dlen)),
      .gnt(gnt), .m_lock(ml1), .m_acc(ma1), .m_busy(mb1), .m_we(mw1),
      .m_addr(mad1), .m_done(md1));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // grant patterns, driven away from the sampling edge
   always @(negedge clk) begin
      cyc++;
      case (gnt_mode)
         0: gnt <= 1'b1;
         1: gnt <= ~gnt;
         default: gnt <= (cyc % 3 == 0);
      endcase
   end

   // count granted writes of the 16-word copy
   always @(posedge clk) begin
      if (rst_n && we0 && gnt) wr0++;
   end

   // cycle-by-cycle comparison against the reference model
   always @(negedge clk) begin
      if (comparing) begin
         chk("R6 u0 lock_held", int'(lk0), int'(ml0));
         chk("R3 u0 req_access", int'(ac0), int'(ma0));
         chk("R3 u0 busy", int'(bz0), int'(mb0));
         chk("R6 u0 done", int'(dn0), int'(md0));
         chk("R4 u0 sram_we", int'(we0), int'(mw0));
         if (mw0) begin
            chk("R5 u0 sram_addr", int'(ad0), mad0);
            chk("R4 u0 wdata zero", int'(wd0 != 0), 0);
         end
         chk("R11 u1 lock_held", int'(lk1), int'(ml1));
         chk("R11 u1 req_access", int'(ac1), int'(ma1));
         chk("R11 u1 busy", int'(bz1), int'(mb1));
         chk("R11 u1 done", int'(dn1), int'(md1));
         chk("R11 u1 sram_we", int'(we1), 0);
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_acq();
      @(negedge clk); acq = 1'b1;
      @(negedge clk); acq = 1'b0;
   endtask

   task automatic do_rel();
      @(negedge clk); rel = 1'b1;
      @(negedge clk); rel = 1'b0;
   endtask

   task automatic do_dlen(input int v);
      @(negedge clk); dwe = 1'b1; dlen = DLW'(v);
      @(negedge clk); dwe = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 200; i++) begin
         if (dn0) break;
         @(negedge clk);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errs++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: state while in reset
      chk("R1 lock in reset", int'(lk0), 1);
      chk("R1 access in reset", int'(ac0), 1);
      chk("R1 busy in reset", int'(bz0), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: first cycle after reset
      chk("R1 lock after reset", int'(lk0), 1);
      chk("R1 access after reset", int'(ac0), 1);
      chk("R1 no write after reset", int'(we0), 0);
      chk("R1 done after reset", int'(dn0), 0);
      comparing = 1'b1;

      // R8: warm-reset wipe with an oversized length clamps to 16 words
      do_dlen(1000);
      wr0 = 0;
      do_rel();
      chk("R3 busy after release", int'(bz0), 1);
      chk("R3 lock held while clearing", int'(lk0), 1);
      wait_done();
      chk("R8 words cleared at clamp", wr0, 16);
      chk("R6 lock free on done", int'(lk0), 0);

      // R2: maximum of 20 and 9 bytes -> 5 words, alternating grant (R5)
      gnt_mode = 1;
      do_acq();
      do_dlen(20);
      do_dlen(9);
      wr0 = 0;
      do_rel();
      wait_done();
      chk("R2 words from max length", wr0, 5);

      // R7 / R9: no length write in this ownership -> nothing cleared
      gnt_mode = 0;
      do_acq();
      wr0 = 0;
      do_rel();
      chk("R7 busy for empty clear", int'(bz0), 1);
      wait_done();
      chk("R9 max reset between owners", wr0, 0);

      // R10: length write and release while free are ignored
      step(2);
      do_dlen(40);
      do_rel();
      chk("R10 release while free", int'(lk0), 0);
      do_acq();
      wr0 = 0;
      do_rel();
      wait_done();
      chk("R10 free length write ignored", wr0, 0);

      // R4: 13 bytes round up to 4 words; stray inputs during the walk
      gnt_mode = 2;
      do_acq();
      do_dlen(13);
      wr0 = 0;
      do_rel();
      do_dlen(60);
      do_acq();
      do_rel();
      chk("R10 owner still shut out", int'(ac0), 0);
      wait_done();
      chk("R4 rounded word count", wr0, 4);
      step(3);
      chk("R10 acquire during walk ignored", int'(lk0), 0);

      // R2: write in the release cycle counts
      gnt_mode = 0;
      do_acq();
      wr0 = 0;
      @(negedge clk); rel = 1'b1; dwe = 1'b1; dlen = DLW'(8);
      @(negedge clk); rel = 1'b0; dwe = 1'b0;
      wait_done();
      chk("R2 same-cycle length write", wr0, 2);

      step(4);
      comparing = 1'b0;
      summary();
      $finish;
   end
endmodule